// File: doc/BRIEF.md
# Fixed-Point RMS Normalisation Unit

The unit normalises a vector of signed Q5.11 activations held in a dual-port scratchpad outside the block. It divides the vector by its root-mean-square and then scales each element by its own gain. After a one-cycle `start` pulse it reads two elements per cycle, one on each scratchpad port. It squares each element, adds the squares into a wide accumulator and keeps a private copy of the vector.

With the sum complete, the unit runs three multi-cycle integer steps in a row. A restoring divider forms the mean. A bit-serial restoring square root follows, and the same divider then forms a reciprocal. The unit then writes the normalised, gain-scaled and saturated results back over the same addresses, two per cycle. `done` pulses once when the last pair has been written. Each result is defined by exact integer arithmetic, so a software model reproduces it bit for bit.

Top module: `rms_norm_unit`

## Requirements
- R1: After reset, and while idle, `done`, `a_we` and `b_we` are low.
- R2: The scratchpad has a registered read with one cycle of latency. In the first cycle after the edge that samples `start`, and in each of the following N/2-1 cycles, the unit reads pair k with `a_addr`=2k and `b_addr`=2k+1, for k = 0 to N/2-1 in ascending order. No write happens in these cycles.
- R3: Let S be the sum of x_i squared over the vector. The unit computes the integer values m = floor(floor(S/N) / 2^11) + 1, r = floor(sqrt(m * 2^11)) and v = floor(2^22 / r). The added 1 LSB keeps r at 45 or above, so the divisor is never zero.
- R4: Each result is y_i = floor(floor(x_i * v / 2^11) * g_i / 2^11). The gain is g_i = 2048 + 2600*(i-12) in Q5.11, and the divisions by 2^11 are arithmetic shifts that round toward minus infinity.
- R5: A result above 32767 is written as 32767, and a result below -32768 is written as -32768. Results are never wrapped.
- R6: The write phase lasts N/2 consecutive cycles. In cycle k both `a_we` and `b_we` are high, `a_addr`=2k and `b_addr`=2k+1, for k = 0 to N/2-1 in ascending order.
- R7: `done` is high for exactly one cycle, which is the cycle right after the last write. No write is active in that cycle.
- R8: A `start` pulse that arrives while an operation is running has no effect. That operation still ends with a single `done`, its results are unchanged, and no new operation begins.
- R9: An all-zero vector produces all-zero results and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to normalise the vector; ignored while busy |
| done | output | 1 | One-cycle completion pulse |
| a_addr | output | AW | Scratchpad port A address (even elements) |
| a_we | output | 1 | Port A write enable |
| a_wdata | output | W | Port A write data |
| a_rdata | input | W | Port A read data, one cycle after the address |
| b_addr | output | AW | Scratchpad port B address (odd elements) |
| b_we | output | 1 | Port B write enable |
| b_wdata | output | W | Port B write data |
| b_rdata | input | W | Port B read data, one cycle after the address |

## Verification
The read addresses are due in the first falling-edge sample after the edge that takes `start`, and then in each of the next eleven cycles. The bench counts those cycles exactly. The write phase begins only after the divide, square-root and divide steps, so the bench does not assume a fixed start time for it. Instead it takes the first write cycle as its reference and requires write k exactly k cycles later, with `done` one cycle after the twelfth write and low in the cycle after that. The bench compares the written values only after `done`, once the final scratchpad edge has committed them.

// File: rtl/rmsn_pkg.sv
package rmsn_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_LOAD,
      S_TAIL,
      S_MKICK,
      S_MWAIT,
      S_QKICK,
      S_QWAIT,
      S_RKICK,
      S_RWAIT,
      S_WRITE,
      S_DONE
   } rmsn_state_t;

   localparam int GAIN_UNITY = 2048;
   localparam int GAIN_STEP  = 2600;

   // Default per-element gain: a linear ramp centred on the middle element.
   function automatic int gain_at(input int idx, input int len);
      return GAIN_UNITY + GAIN_STEP * (idx - len / 2);
   endfunction

endpackage

// File: rtl/rmsn_udiv.sv
// Restoring unsigned divider, one quotient bit per cycle.
module rmsn_udiv #(
   parameter int NUM_W = 40,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem_q, den_q;
   logic [NUM_W-1:0] quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   logic [DEN_W:0]   shifted;
   logic [DEN_W+1:0] trial;
   logic             neg;

   assign shifted = {rem_q, quo_q[NUM_W-1]};
   assign trial   = {1'b0, shifted} - {2'b00, den_q};
   assign neg     = trial[DEN_W+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         den_q  <= den;
         quo_q  <= num;
         cnt_q  <= CNT_W'(NUM_W);
         done_q <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q  <= neg ? shifted[DEN_W-1:0] : trial[DEN_W-1:0];
         quo_q  <= {quo_q[NUM_W-2:0], ~neg};
         cnt_q  <= cnt_q - CNT_W'(1);
         done_q <= (cnt_q == CNT_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign quo  = quo_q;
endmodule

// File: rtl/rmsn_isqrt.sv
// Bit-serial restoring integer square root, one result bit per cycle.
module rmsn_isqrt #(
   parameter int RT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2*RT_W-1:0] rad,
   output logic              done,
   output logic [RT_W-1:0]   root
);
   localparam int RAD_W = 2 * RT_W;
   localparam int REM_W = RT_W + 3;
   localparam int CNT_W = $clog2(RT_W + 1);

   logic [RAD_W-1:0] rad_q;
   logic [REM_W-1:0] rem_q;
   logic [RT_W-1:0]  root_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   logic [REM_W-1:0] rem_sh, trial;
   logic             fits;

   assign rem_sh = {rem_q[REM_W-3:0], rad_q[RAD_W-1 -: 2]};
   assign trial  = REM_W'({root_q, 2'b01});
   assign fits   = (rem_sh >= trial);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rad_q  <= '0;
         rem_q  <= '0;
         root_q <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (start) begin
         rad_q  <= rad;
         rem_q  <= '0;
         root_q <= '0;
         cnt_q  <= CNT_W'(RT_W);
         done_q <= 1'b0;
      end else if (cnt_q != '0) begin
         rad_q  <= rad_q << 2;
         rem_q  <= fits ? (rem_sh - trial) : rem_sh;
         root_q <= {root_q[RT_W-2:0], fits};
         cnt_q  <= cnt_q - CNT_W'(1);
         done_q <= (cnt_q == CNT_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign root = root_q;
endmodule

// File: rtl/rmsn_gain_rom.sv
// Per-element gain table, filled at elaboration from the package ramp.
module rmsn_gain_rom
   import rmsn_pkg::*;
#(
   parameter int N  = 24,
   parameter int W  = 16,
   parameter int AW = 5
) (
   input  logic [AW-1:0]       addr,
   output logic signed [W-1:0] gain
);
   logic signed [W-1:0] rom_w [N];

   for (genvar i = 0; i < N; i++) begin : g_entry
      assign rom_w[i] = W'(gain_at(i, N));
   end

   assign gain = (int'(addr) < N) ? rom_w[addr] : '0;
endmodule

// File: rtl/rmsn_lane.sv
// One element lane: square for the sum, and normalise/scale/saturate for output.
module rmsn_lane #(
   parameter int W     = 16,
   parameter int FRAC  = 11,
   parameter int INV_W = 18
) (
   input  logic signed [W-1:0] x,
   input  logic [INV_W-1:0]    inv,
   input  logic signed [W-1:0] gain,
   output logic [2*W-1:0]      sq,
   output logic signed [W-1:0] y
);
   localparam int P1W = W + INV_W;
   localparam int TW  = P1W - FRAC;
   localparam int P2W = TW + W;
   localparam logic signed [P2W-1:0] YMAX = P2W'((1 << (W - 1)) - 1);
   localparam logic signed [P2W-1:0] YMIN = ~YMAX;

   logic signed [2*W-1:0] xs;
   logic signed [P1W-1:0] xe, ie, p1, p1s;
   logic signed [TW-1:0]  t;
   logic signed [P2W-1:0] te, ge, p2, p2s;

   assign xs  = (2*W)'(x);
   assign sq  = xs * xs;

   assign xe  = P1W'(x);
   assign ie  = signed'(P1W'(inv));
   assign p1  = xe * ie;
   assign p1s = p1 >>> FRAC;
   assign t   = p1s[TW-1:0];

   assign te  = P2W'(t);
   assign ge  = P2W'(gain);
   assign p2  = te * ge;
   assign p2s = p2 >>> FRAC;

   always_comb begin
      if (p2s > YMAX)      y = YMAX[W-1:0];
      else if (p2s < YMIN) y = YMIN[W-1:0];
      else                 y = p2s[W-1:0];
   end
endmodule

// File: rtl/rms_norm_unit.sv
module rms_norm_unit
   import rmsn_pkg::*;
#(
   parameter int N     = 24,
   parameter int W     = 16,
   parameter int FRAC  = 11,
   parameter int ACC_W = 40,
   parameter int AW    = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          done,
   output logic [AW-1:0] a_addr,
   output logic          a_we,
   output logic [W-1:0]  a_wdata,
   input  logic [W-1:0]  a_rdata,
   output logic [AW-1:0] b_addr,
   output logic          b_we,
   output logic [W-1:0]  b_wdata,
   input  logic [W-1:0]  b_rdata
);
   localparam int LANES = 2;
   localparam int HALF  = N / LANES;
   localparam int IW    = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int SQ_W  = 2 * W;
   localparam int RAD_W = 2 * W;
   localparam int INV_W = W + 2;
   localparam logic [ACC_W-1:0] RECIP_NUM = ACC_W'(1) << (2 * FRAC);

   if (N % LANES != 0) begin : g_bad_len
      $error("rms_norm_unit: vector length must be even");
   end
   if ((1 << AW) < N) begin : g_bad_aw
      $error("rms_norm_unit: address width too small");
   end
   if (ACC_W < SQ_W + $clog2(N)) begin : g_bad_acc
      $error("rms_norm_unit: accumulator too narrow");
   end
   if (ACC_W <= 2 * FRAC) begin : g_bad_frac
      $error("rms_norm_unit: accumulator cannot hold reciprocal numerator");
   end

   rmsn_state_t         state_q;
   logic [IW-1:0]       idx_q, rix_q;
   logic                rv_q;
   logic [ACC_W-1:0]    acc_q, mean_q;
   logic [W-1:0]        root_q;
   logic [INV_W-1:0]    inv_q;
   logic signed [W-1:0] xbuf [N];

   logic [AW-1:0]       base_addr, rd_base;
   logic [W-1:0]        rdata_arr [LANES];
   logic [AW-1:0]       lane_addr [LANES];
   logic signed [W-1:0] lane_x    [LANES];
   logic signed [W-1:0] lane_g    [LANES];
   logic signed [W-1:0] lane_y    [LANES];
   logic [SQ_W-1:0]     lane_sq   [LANES];

   logic                div_start, div_done, sq_start, sq_done;
   logic [ACC_W-1:0]    div_num, div_quo, ms_w;
   logic [W-1:0]        div_den, sq_root;
   logic [RAD_W-1:0]    rad_w;
   logic                writing;

   assign writing      = (state_q == S_WRITE);
   assign base_addr    = AW'({idx_q, 1'b0});
   assign rd_base      = AW'({rix_q, 1'b0});
   assign rdata_arr[0] = a_rdata;
   assign rdata_arr[1] = b_rdata;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_addr[l] = base_addr + AW'(l);
      assign lane_x[l]    = writing ? xbuf[lane_addr[l]] : signed'(rdata_arr[l]);

      rmsn_gain_rom #(.N(N), .W(W), .AW(AW)) u_rom (
         .addr (lane_addr[l]),
         .gain (lane_g[l])
      );

      rmsn_lane #(.W(W), .FRAC(FRAC), .INV_W(INV_W)) u_lane (
         .x    (lane_x[l]),
         .inv  (inv_q),
         .gain (lane_g[l]),
         .sq   (lane_sq[l]),
         .y    (lane_y[l])
      );
   end

   // Divider is shared between the mean and the reciprocal.
   assign div_start = (state_q == S_MKICK) || (state_q == S_RKICK);
   assign div_num   = (state_q == S_RKICK) ? RECIP_NUM : acc_q;
   assign div_den   = (state_q == S_RKICK) ? root_q : W'(N);
   assign sq_start  = (state_q == S_QKICK);
   assign ms_w      = (mean_q >> FRAC) + ACC_W'(1);
   assign rad_w     = RAD_W'(ms_w << FRAC);

   rmsn_udiv #(.NUM_W(ACC_W), .DEN_W(W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (div_num),
      .den   (div_den),
      .done  (div_done),
      .quo   (div_quo)
   );

   rmsn_isqrt #(.RT_W(W)) u_sqrt (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sq_start),
      .rad   (rad_w),
      .done  (sq_done),
      .root  (sq_root)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         rix_q   <= '0;
         rv_q    <= 1'b0;
         acc_q   <= '0;
         mean_q  <= '0;
         root_q  <= '0;
         inv_q   <= '0;
      end else begin
         rv_q <= 1'b0;
         if (rv_q) begin
            acc_q <= acc_q + ACC_W'(lane_sq[0]) + ACC_W'(lane_sq[1]);
         end
         case (state_q)
            S_IDLE: if (start) begin
               state_q <= S_LOAD;
               idx_q   <= '0;
               acc_q   <= '0;
            end
            S_LOAD: begin
               rv_q  <= 1'b1;
               rix_q <= idx_q;
               idx_q <= idx_q + IW'(1);
               if (idx_q == IW'(HALF - 1)) state_q <= S_TAIL;
            end
            S_TAIL:  state_q <= S_MKICK;
            S_MKICK: state_q <= S_MWAIT;
            S_MWAIT: if (div_done) begin
               mean_q  <= div_quo;
               state_q <= S_QKICK;
            end
            S_QKICK: state_q <= S_QWAIT;
            S_QWAIT: if (sq_done) begin
               root_q  <= sq_root;
               state_q <= S_RKICK;
            end
            S_RKICK: state_q <= S_RWAIT;
            S_RWAIT: if (div_done) begin
               inv_q   <= INV_W'(div_quo);
               idx_q   <= '0;
               state_q <= S_WRITE;
            end
            S_WRITE: begin
               idx_q <= idx_q + IW'(1);
               if (idx_q == IW'(HALF - 1)) state_q <= S_DONE;
            end
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // Private copy of the vector, captured as the reads return.
   always_ff @(posedge clk) begin
      if (rv_q) begin
         for (int l = 0; l < LANES; l++) begin
            xbuf[rd_base + AW'(l)] <= signed'(rdata_arr[l]);
         end
      end
   end

   assign a_addr  = lane_addr[0];
   assign b_addr  = lane_addr[1];
   assign a_we    = writing;
   assign b_we    = writing;
   assign a_wdata = lane_y[0];
   assign b_wdata = lane_y[1];
   assign done    = (state_q == S_DONE);
endmodule

// File: rtl/rmsn_chk.sv
module rmsn_chk #(
   parameter int AW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic          a_we,
   input logic          b_we,
   input logic [AW-1:0] a_addr,
   input logic [AW-1:0] b_addr
);
   // R6
   pair_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_we |-> (b_we && !a_addr[0] && b_addr == a_addr + AW'(1)));

   // R6
   first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_we) |-> (a_addr == '0));

   // R6
   write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we && $past(a_we)) |-> (a_addr == $past(a_addr) + AW'(2)));

   // R7
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(a_we) && !a_we && !b_we));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   write_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a_we) |-> done);
endmodule

bind rms_norm_unit rmsn_chk #(.AW(AW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .done   (done),
   .a_we   (a_we),
   .b_we   (b_we),
   .a_addr (a_addr),
   .b_addr (b_addr)
);

// File: tb/rms_norm_unit_tb.sv
module rms_norm_unit_tb;
   localparam int N  = 24;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done, a_we, b_we;
   logic [AW-1:0] a_addr, b_addr;
   logic [15:0] a_wdata, b_wdata;
   logic [15:0] a_rdata = '0;
   logic [15:0] b_rdata = '0;

   logic [15:0] mem [32];
   longint x_v [N];
   longint exp_y [N];
   int checks = 0;
   int fails = 0;
   int seed = 12345;

   always #2.5 clk = ~clk;

   rms_norm_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata)
   );

   // Scratchpad model: two ports, registered read
   always @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wdata;
      if (b_we) mem[b_addr] <= b_wdata;
      a_rdata <= mem[a_addr];
      b_rdata <= mem[b_addr];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic longint ref_isqrt(input longint v);
      longint r = 0;
      for (int b = 15; b >= 0; b--) begin
         longint c;
         c = r | (longint'(1) << b);
         if (c * c <= v) r = c;
      end
      return r;
   endfunction

   task automatic compute_expected();
      longint s = 0;
      longint m, r, v, t, p;
      for (int i = 0; i < N; i++) s += x_v[i] * x_v[i];
      m = ((s / N) >>> 11) + 1;
      r = ref_isqrt(m << 11);
      v = (longint'(1) << 22) / r;
      for (int i = 0; i < N; i++) begin
         longint g;
         g = 2048 + 2600 * (i - 12);
         t = (x_v[i] * v) >>> 11;
         p = (t * g) >>> 11;
         if (p > 32767) p = 32767;
         if (p < -32768) p = -32768;
         exp_y[i] = p;
      end
   endtask

   task automatic run_vec(input string req, input bit restart);
      int cyc = 0;
      int w = 0;
      int first = 0;
      int extra = 0;
      compute_expected();
      @(negedge clk);
      for (int i = 0; i < N; i++) mem[i] = 16'(x_v[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < N / 2; k++) begin
         if (k > 0) @(negedge clk);
         chk(a_addr == AW'(2 * k) && b_addr == AW'(2 * k + 1) && !a_we && !b_we,
             "R2", "read pair address", longint'(a_addr), longint'(2 * k));
      end
      while (w < N / 2 && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         start = (restart && cyc == 20);
         if (done) begin
            chk(1'b0, "R7", "done before last write", longint'(w), 12);
         end
         if (a_we) begin
            if (w == 0) first = cyc;
            chk(a_addr == AW'(2 * w) && b_addr == AW'(2 * w + 1) && b_we && cyc == first + w,
                "R6", "write pair address/timing", longint'(a_addr), longint'(2 * w));
            w++;
         end
      end
      start = 1'b0;
      chk(cyc < 5000, "R6", "write phase reached", longint'(cyc), 0);
      @(negedge clk);
      chk(done == 1'b1 && !a_we && !b_we, "R7", "done after last write", longint'(done), 1);
      @(negedge clk);
      chk(done == 1'b0, "R7", "done one cycle wide", longint'(done), 0);
      if (restart) begin
         for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (done || a_we || b_we) extra++;
         end
         chk(extra == 0, "R8", "no activity after ignored start", longint'(extra), 0);
      end
      for (int i = 0; i < N; i++) begin
         chk(longint'($signed(mem[i])) == exp_y[i], req, $sformatf("element %0d", i),
             longint'($signed(mem[i])), exp_y[i]);
      end
   endtask

   function automatic int next_rand();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 8) & 32'h7fff;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all): actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(done == 1'b0 && a_we == 1'b0 && b_we == 1'b0, "R1", "outputs in reset",
          longint'({done, a_we, b_we}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && a_we == 1'b0 && b_we == 1'b0, "R1", "outputs idle",
          longint'({done, a_we, b_we}), 0);

      // R3 R4: ramp vector, with a start pulse mid-run (R8)
      for (int i = 0; i < N; i++) x_v[i] = (i - 12) * 300;
      run_vec("R3,R4,R8", 1'b1);

      // R9: all zeros
      for (int i = 0; i < N; i++) x_v[i] = 0;
      run_vec("R9", 1'b0);

      // R5: two large elements, the rest zero, drive both saturation limits
      for (int i = 0; i < N; i++) x_v[i] = 0;
      x_v[0] = 16000;
      x_v[23] = 16000;
      run_vec("R5", 1'b0);

      // R5: full-scale negative and positive vectors
      for (int i = 0; i < N; i++) x_v[i] = -32768;
      run_vec("R5", 1'b0);
      for (int i = 0; i < N; i++) x_v[i] = 32767;
      run_vec("R5", 1'b0);

      // R3 R4: smallest nonzero magnitude, epsilon dominates
      for (int i = 0; i < N; i++) x_v[i] = (i % 2 == 0) ? 1 : -1;
      run_vec("R3,R4", 1'b0);

      // R3 R4 R5: amplitude sweep of pseudo-random vectors
      for (int s = 0; s < 16; s++) begin
         for (int i = 0; i < N; i++) begin
            int raw;
            raw = next_rand();
            x_v[i] = (longint'(raw) - 16384) >>> (15 - s);
            if (s == 15) x_v[i] = longint'(raw) * 2 - 32768;
         end
         run_vec("R3,R4,R5", 1'b0);
      end

      repeat (5) @(negedge clk);
      chk(done == 1'b0 && a_we == 1'b0, "R1", "idle after runs", longint'({done, a_we}), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule